// File: doc/BRIEF.md
# Bus Write Data-Cycle Sequencer

This block places the cycles of one processor write onto a multiplexed address/data bus. A request carries the bus width, the kind of write (a full cache-line block or a single transfer), whether a single transfer is wider than one word, a spacing-pattern code and an address-to-data gap. Once the request is accepted and the write-ready input has been seen, the block drives one address cycle. It then inserts the programmed number of idle cycles and emits the data beats, spaced by the selected repeating rhythm of data and idle cycles.

The valid-out strobe marks every cycle on which the bus carries something: the address cycle and each data beat. Separate address and data flags, and a beat index, tell the data source what to place on the bus. A one-cycle done pulse closes the transfer. A pattern code outside the defined set is refused at once with an error pulse. Bus arbitration and the data path itself sit outside this block.

Top module: `wr_beat_seq`

## Requirements
- R1: After reset, valid_out, addr_cyc, data_cyc, busy, done and cfg_err are all 0 and ad_out is 0.
- R2: A start seen in the idle state with pat_code from 9 to 15 raises cfg_err for exactly the next cycle, leaves busy at 0 and produces no bus cycle, even with wr_ready high.
- R3: After an accepted start, no valid_out appears while wr_ready is low. The address cycle comes in the cycle after the one in which wr_ready is sampled high.
- R4: The address cycle lasts one cycle with valid_out=1, addr_cyc=1 and data_cyc=0. ad_out carries wr_addr, with bits [2:0] forced to 0 when the write is a doubleword access (blk_wr=1 or wide=1). Outside the address cycle ad_out is 0.
- R5: Exactly ad_gap (0 to 7) idle cycles separate the address cycle from the first data beat. With ad_gap=0 the first beat directly follows the address cycle.
- R6: From the first beat on, each pattern repeats with a fixed period: data cycles come first in every period and idle cycles follow. Per pattern code (data cycles, idle cycles): 0=(1,0), 1=(2,1), 2=(2,2), 3=(1,1), 4=(2,3), 5=(2,4), 6=(1,2), 7=(2,6), 8=(1,3). The same rhythm applies to word beats on a 32-bit bus.
- R7: A block write (blk_wr=1) emits 4 beats when bus32=0 and 8 beats when bus32=1.
- R8: A single write emits 1 beat. With bus32=1 and wide=1 it emits 2 beats. With bus32=0, wide has no effect.
- R9: done is high for exactly one cycle, the cycle after the last beat, with valid_out low. busy is high from the cycle after the start through the done cycle, and 0 after it.
- R10: valid_out is high only on address and data cycles. During each data beat, beat_num gives that beat's index, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a write (sampled when idle) |
| bus32 | input | 1 | 1 = 32-bit bus, 0 = 64-bit bus |
| blk_wr | input | 1 | 1 = block (cache-line) write |
| wide | input | 1 | Single write wider than 4 bytes |
| pat_code | input | 4 | Beat spacing pattern code |
| ad_gap | input | 3 | Idle cycles between address and data |
| wr_addr | input | AW | Write address |
| wr_ready | input | 1 | Target can accept a write |
| valid_out | output | 1 | Bus carries address or data this cycle |
| addr_cyc | output | 1 | Address cycle |
| data_cyc | output | 1 | Data beat cycle |
| ad_out | output | AW | Address during the address cycle, else 0 |
| beat_num | output | 3 | Index of the current beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | Rejected pattern code pulse |

## Verification
The assertions check, on every cycle, the rules that hold at any moment. The address cycle never repeats. It only follows a sampled write-ready. Address, data and done cycles never overlap. done is a single pulse followed by idle. An error pulse never coincides with a transfer. The exact spacing of beats for each pattern code, the address-to-data gap, the beat count per bus width and write kind, and the masking of the low address bits depend on the request. Only the bench's vector table and directed cases can show these.

// File: rtl/wr_beat_seq.sv
module wr_beat_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bus32,
  input  logic          blk_wr,
  input  logic          wide,
  input  logic [3:0]    pat_code,
  input  logic [2:0]    ad_gap,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_ready,
  output logic          valid_out,
  output logic          addr_cyc,
  output logic          data_cyc,
  output logic [AW-1:0] ad_out,
  output logic [2:0]    beat_num,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ADDR, S_GAP, S_DATA, S_DONE} st_t;

  st_t           st;
  logic [1:0]    r_dc;
  logic [3:0]    r_per;
  logic [2:0]    r_last;
  logic [2:0]    r_gap;
  logic [AW-1:0] r_addr;
  logic          r_dw;
  logic [2:0]    gap_cnt;
  logic [3:0]    pos;
  logic [2:0]    beat;

  logic [1:0] n_dc;
  logic [2:0] n_idle;
  logic       bad_code;

  always_comb begin
    case (pat_code)
      4'd0: begin n_dc = 2'd1; n_idle = 3'd0; end
      4'd1: begin n_dc = 2'd2; n_idle = 3'd1; end
      4'd2: begin n_dc = 2'd2; n_idle = 3'd2; end
      4'd3: begin n_dc = 2'd1; n_idle = 3'd1; end
      4'd4: begin n_dc = 2'd2; n_idle = 3'd3; end
      4'd5: begin n_dc = 2'd2; n_idle = 3'd4; end
      4'd6: begin n_dc = 2'd1; n_idle = 3'd2; end
      4'd7: begin n_dc = 2'd2; n_idle = 3'd6; end
      4'd8: begin n_dc = 2'd1; n_idle = 3'd3; end
      default: begin n_dc = 2'd1; n_idle = 3'd0; end
    endcase
  end

  assign bad_code = pat_code > 4'd8;

  wire is_d = ({2'b00, r_dc} > pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cfg_err <= 1'b0;
      r_dc    <= 2'd1;
      r_per   <= 4'd1;
      r_last  <= 3'd0;
      r_gap   <= 3'd0;
      r_addr  <= '0;
      r_dw    <= 1'b0;
      gap_cnt <= 3'd0;
      pos     <= 4'd0;
      beat    <= 3'd0;
    end else begin
      cfg_err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_code) cfg_err <= 1'b1;
          else begin
            r_dc   <= n_dc;
            r_per  <= {2'b00, n_dc} + {1'b0, n_idle};
            r_last <= blk_wr ? (bus32 ? 3'd7 : 3'd3) : ((bus32 && wide) ? 3'd1 : 3'd0);
            r_gap  <= ad_gap;
            r_addr <= wr_addr;
            r_dw   <= blk_wr | wide;
            st     <= S_WAIT;
          end
        end
        S_WAIT: if (wr_ready) st <= S_ADDR;
        S_ADDR: begin
          gap_cnt <= r_gap;
          pos     <= 4'd0;
          beat    <= 3'd0;
          st      <= (r_gap != 3'd0) ? S_GAP : S_DATA;
        end
        S_GAP: begin
          gap_cnt <= gap_cnt - 3'd1;
          if (gap_cnt == 3'd1) st <= S_DATA;
        end
        S_DATA: begin
          pos <= (pos == r_per - 4'd1) ? 4'd0 : pos + 4'd1;
          if (is_d) begin
            if (beat == r_last) st <= S_DONE;
            else beat <= beat + 3'd1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign addr_cyc  = (st == S_ADDR);
  assign data_cyc  = (st == S_DATA) && is_d;
  assign valid_out = addr_cyc | data_cyc;
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE);
  assign beat_num  = data_cyc ? beat : 3'd0;
  assign ad_out    = addr_cyc ? (r_dw ? {r_addr[AW-1:3], 3'b000} : r_addr) : '0;

endmodule

module wr_beat_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ready,
  input logic addr_cyc,
  input logic data_cyc,
  input logic done,
  input logic busy,
  input logic cfg_err
);
  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
  // R3
  addr_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_cyc) |-> $past(wr_ready));
  // R4
  addr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cyc |=> !addr_cyc);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_cyc, data_cyc, done}));
endmodule

bind wr_beat_seq wr_beat_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .addr_cyc(addr_cyc),
  .data_cyc(data_cyc), .done(done), .busy(busy), .cfg_err(cfg_err)
);

// File: tb/wr_beat_seq_tb.sv
module wr_beat_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bus32 = 1'b0, blk_wr = 1'b0, wide = 1'b0, wr_ready = 1'b0;
  logic [3:0] pat_code = 4'd0;
  logic [2:0] ad_gap = 3'd0;
  logic [31:0] wr_addr = 32'd0;
  logic valid_out, addr_cyc, data_cyc, busy, done, cfg_err;
  logic [31:0] ad_out;
  logic [2:0] beat_num;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  wr_beat_seq #(.AW(32)) dut_i (.*);

  // {bus32, blk, wide, pat[3:0], gap[2:0], per[3:0], dc[1:0], beats[3:0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,4'd0,3'd0,4'd1,2'd1,4'd4},
    {1'b0,1'b1,1'b0,4'd1,3'd2,4'd3,2'd2,4'd4},
    {1'b1,1'b1,1'b0,4'd3,3'd0,4'd2,2'd1,4'd8},
    {1'b1,1'b1,1'b0,4'd7,3'd7,4'd8,2'd2,4'd8},
    {1'b0,1'b0,1'b1,4'd2,3'd1,4'd4,2'd2,4'd1},
    {1'b1,1'b0,1'b1,4'd6,3'd3,4'd3,2'd1,4'd2},
    {1'b1,1'b0,1'b0,4'd8,3'd0,4'd4,2'd1,4'd1},
    {1'b0,1'b1,1'b0,4'd4,3'd5,4'd5,2'd2,4'd4},
    {1'b0,1'b1,1'b0,4'd5,3'd1,4'd6,2'd2,4'd4},
    {1'b1,1'b1,1'b0,4'd8,3'd4,4'd4,2'd1,4'd8},
    {1'b0,1'b1,1'b0,4'd6,3'd0,4'd3,2'd1,4'd4},
    {1'b1,1'b1,1'b0,4'd2,3'd6,4'd4,2'd2,4'd8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_vec(input int i);
    logic [19:0] v;
    int gap, per, dc, beats, eb, k, bad_gap, bad_pat, nd, bad_idx;
    logic [31:0] exp_ad;
    bit quiet;
    v = VEC[i];
    gap = v[12:10]; per = v[9:6]; dc = v[5:4]; beats = v[3:0];
    @(negedge clk);
    bus32 = v[19]; blk_wr = v[18]; wide = v[17]; pat_code = v[16:13]; ad_gap = v[12:10];
    wr_addr = 32'hA5A5_1237 + 32'(i * 3); start = 1'b1; wr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    quiet = 1'b1;
    for (int w = 0; w < (i % 3) + 1; w++) begin
      if (valid_out) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R3 no cycle before ready", 0, 0);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    exp_ad = (v[18] | v[17]) ? {wr_addr[31:3], 3'b000} : wr_addr;
    chk(addr_cyc && valid_out && !data_cyc, "R4 address cycle", int'(addr_cyc), 1);
    chk(ad_out == exp_ad, "R4 address value", int'(ad_out), int'(exp_ad));
    bad_gap = 0; bad_pat = 0; nd = 0; bad_idx = 0; eb = 0; k = 0;
    while (eb < beats && k < 200) begin
      bit ev;
      @(negedge clk);
      k++;
      if (k <= gap) begin
        if (valid_out) bad_gap++;
      end else begin
        ev = ((k - gap - 1) % per) < dc;
        if (valid_out !== ev || data_cyc !== ev) bad_pat++;
        if (data_cyc) nd++;
        if (ev) begin
          if (int'(beat_num) != eb) bad_idx++;
          eb++;
        end
      end
    end
    chk(bad_gap == 0, "R5 address-to-data gap", bad_gap, 0);
    chk(bad_pat == 0, "R6 beat pattern", bad_pat, 0);
    chk(bad_idx == 0, "R10 beat index", bad_idx, 0);
    if (v[18]) chk(nd == beats, "R7 block beat count", nd, beats);
    else       chk(nd == beats, "R8 single beat count", nd, beats);
    @(negedge clk);
    chk(done && !valid_out && busy, "R9 done pulse", int'(done), 1);
    @(negedge clk);
    chk(!done && !busy && !valid_out, "R9 return to idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid_out && !addr_cyc && !data_cyc && !busy && !done && !cfg_err && ad_out == 0,
        "R1 reset state", int'(valid_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !valid_out && ad_out == 0, "R1 idle after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: bad code rejected, even with ready high
    @(negedge clk);
    pat_code = 4'd9; blk_wr = 1'b1; bus32 = 1'b0; start = 1'b1; wr_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err && !busy, "R2 error pulse", int'(cfg_err), 1);
    @(negedge clk);
    chk(!cfg_err, "R2 error one cycle", int'(cfg_err), 0);
    begin
      bit q;
      q = 1'b1;
      for (int w = 0; w < 6; w++) begin
        if (valid_out || busy) q = 1'b0;
        @(negedge clk);
      end
      chk(q, "R2 no transfer", 0, 0);
    end
    pat_code = 4'd15; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err && !busy, "R2 error code 15", int'(cfg_err), 1);
    wr_ready = 1'b0;

    // R8: wide ignored on 64-bit bus, single narrow write keeps low address bits
    @(negedge clk);
    pat_code = 4'd0; ad_gap = 3'd0; bus32 = 1'b0; blk_wr = 1'b0; wide = 1'b0;
    wr_addr = 32'h0000_1235; start = 1'b1;
    @(negedge clk);
    start = 1'b0; wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    chk(ad_out == 32'h0000_1235, "R4 narrow address unmasked", int'(ad_out), 32'h1235);
    @(negedge clk);
    chk(data_cyc && beat_num == 0, "R8 single beat", int'(data_cyc), 1);
    @(negedge clk);
    chk(done && !data_cyc, "R8 single ends after one beat", int'(done), 1);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule